// File: doc/BRIEF.md
# Register-Controlled I2C Master

This block is a small I2C bus master that software drives through a handful of byte-wide registers. Software writes a 7-bit device address with the direction in its least significant bit, one or two outgoing data bytes and a length choice. It then sets a start bit. The engine generates START, sends the address byte and moves one or two data bytes, handling the acknowledge bit after every byte, and closes with STOP. Both bus lines are open-drain: the block only ever pulls them low.

The start bit doubles as the busy flag. It reads 1 from the write that sets it until STOP has been placed on the bus, and the hardware then clears it. While it is set, writes to the configuration registers are dropped, so the transfer in flight keeps the values it began with. A missing acknowledge sets a sticky error bit, and that bit clears only when the next transfer starts. Read transfers place the first received byte and the second received byte in two separate result registers. The bus clock comes from a programmable divider: every quarter of an SCL period lasts a fixed number of system clocks.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, every register reads 0x00 except the divider register, which reads DIV_INIT (default 3), and neither bus line is pulled.
- R2: Register offsets: 0 device address, 1 first transmit byte, 2 second transmit byte, 3 divider, 4 first read byte, 5 second read byte, 6 control/status. Control/status bit 0 is the length bit (1 = two data bytes), bit 1 is start/busy, bit 2 is acknowledge error, and bits 7..3 read 0.
- R3: Writing control/status with bit 1 set while idle starts a transfer. Bit 1 reads 1 from the next cycle until STOP has been generated, then reads 0.
- R4: A write transfer (address LSB 0) sends the address byte, then transmit byte 1, then transmit byte 2 when the length bit is 1, each MSB first, then STOP.
- R5: A read transfer (address LSB 1) stores the first received byte at offset 4 and the second at offset 5. The master acknowledges (SDA low) every read byte except the final one, which it answers with a not-acknowledge.
- R6: With the length bit 0, exactly one data byte moves after the address, and a one-byte read leaves offset 5 unchanged.
- R7: A not-acknowledge on the address byte or on a transmitted data byte sets the acknowledge-error bit, abandons the remaining bytes, issues STOP and clears busy.
- R8: The acknowledge-error bit stays set through control/status writes that do not start a transfer, and it reads 0 in the cycle after a new transfer is started.
- R9: While busy reads 1, writes to offsets 0, 1, 2, 3 and 6 have no effect.
- R10: Each SCL quarter lasts divider+1 system clocks, and SCL stays high for two quarters per bit. SDA never changes in the same cycle as SCL. Outside START and STOP, SDA changes only while SCL is low.
- R11: Writes to offsets 4 and 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A sequencer that loses its place in the bit count shows up on the bus as a byte of the wrong length. The bench's slave model sees this within one byte time, as a misplaced acknowledge or a shifted received value. A start/busy or error flag in the wrong state is visible on the next read of control/status, one cycle after the event that should have changed it. A wrong bus-line driver is caught in the same clock: the monitor flags SDA and SCL moving together. A wrong quarter length shows up as a wrong SCL high width, measured on the next falling edge of SCL.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_BIT   = 2'd2,
    SQ_STOP  = 2'd3
  } seq_state_e;

  localparam logic [2:0] A_DEV = 3'd0;
  localparam logic [2:0] A_TX0 = 3'd1;
  localparam logic [2:0] A_TX1 = 3'd2;
  localparam logic [2:0] A_DIV = 3'd3;
  localparam logic [2:0] A_RD0 = 3'd4;
  localparam logic [2:0] A_RD1 = 3'd5;
  localparam logic [2:0] A_CSR = 3'd6;

  localparam int CSR_LEN = 0;
  localparam int CSR_GO  = 1;

  // number of data bytes after the address byte
  function automatic logic [1:0] data_bytes(input logic len);
    return len ? 2'd2 : 2'd1;
  endfunction

  // SCL pulled low in these quarters of each state
  function automatic logic scl_pulled(input seq_state_e st, input logic [1:0] ph);
    case (st)
      SQ_START:        return ph == 2'd3;
      SQ_BIT, SQ_STOP: return ph < 2'd2;
      default:         return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] csr_pack(input logic len, input logic busy, input logic ake);
    return {5'b0, ake, busy, len};
  endfunction

endpackage

// File: rtl/i2cm_qtr_div.sv
module i2cm_qtr_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)        cnt_q <= '0;
    else if (cnt_q == div)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == div);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick); // R10

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       go,
  input  logic       len,
  input  logic [7:0] dev_addr,
  input  logic [7:0] tx0,
  input  logic [7:0] tx1,
  input  logic       sda_in,
  output logic       running,
  output logic       done,
  output logic       nack_evt,
  output logic       rd_we,
  output logic       rd_idx,
  output logic [7:0] rd_data,
  output logic       scl_low,
  output logic       sda_low
);

  seq_state_e st_q;
  logic [1:0] ph_q;
  logic [1:0] byte_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       sda_q;
  logic       nack_q;

  logic rw, is_tx, last, data_phase, drive_bit, byte_end, abort;

  assign rw         = dev_addr[0];
  assign is_tx      = (byte_q == 2'd0) || !rw;
  assign last       = byte_q == data_bytes(len);
  assign data_phase = bit_q < 4'd8;
  assign abort      = is_tx && nack_q;

  always_comb begin
    if (data_phase) drive_bit = is_tx ? ~sh_q[7] : 1'b0;
    else            drive_bit = is_tx ? 1'b0 : !last;
  end

  assign byte_end = tick && st_q == SQ_BIT && ph_q == 2'd3 && !data_phase;
  assign nack_evt = tick && st_q == SQ_BIT && ph_q == 2'd2 && !data_phase && is_tx && sda_in;
  assign done     = tick && st_q == SQ_STOP && ph_q == 2'd3;
  assign rd_we    = byte_end && !is_tx;
  assign rd_idx   = byte_q == 2'd2;
  assign rd_data  = sh_q;
  assign running  = st_q != SQ_IDLE;
  assign scl_low  = scl_pulled(st_q, ph_q);
  assign sda_low  = sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      ph_q   <= 2'd0;
      byte_q <= 2'd0;
      bit_q  <= 4'd0;
      sh_q   <= 8'd0;
      sda_q  <= 1'b0;
      nack_q <= 1'b0;
    end else if (st_q == SQ_IDLE) begin
      if (go) begin
        st_q   <= SQ_START;
        ph_q   <= 2'd0;
        nack_q <= 1'b0;
      end
    end else if (tick) begin
      ph_q <= ph_q + 2'd1;
      case (st_q)
        SQ_START: begin
          if (ph_q == 2'd1) sda_q <= 1'b1;
          if (ph_q == 2'd3) begin
            st_q   <= SQ_BIT;
            byte_q <= 2'd0;
            bit_q  <= 4'd0;
            sh_q   <= dev_addr;
          end
        end
        SQ_BIT: begin
          if (ph_q == 2'd0) sda_q <= drive_bit;
          if (ph_q == 2'd2) begin
            if (data_phase && !is_tx) sh_q <= {sh_q[6:0], sda_in};
            if (!data_phase && is_tx && sda_in) nack_q <= 1'b1;
          end
          if (ph_q == 2'd3) begin
            if (data_phase) begin
              bit_q <= bit_q + 4'd1;
              if (is_tx) sh_q <= {sh_q[6:0], 1'b0};
            end else if (last || abort) begin
              st_q <= SQ_STOP;
            end else begin
              byte_q <= byte_q + 2'd1;
              bit_q  <= 4'd0;
              sh_q   <= (byte_q == 2'd0) ? tx0 : tx1;
            end
          end
        end
        SQ_STOP: begin
          if (ph_q == 2'd0) sda_q <= 1'b1;
          if (ph_q == 2'd3) begin
            sda_q <= 1'b0;
            st_q  <= SQ_IDLE;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_SDA_NOT_WITH_SCL: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_low) |-> $stable(sda_low)); // R10
  AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_BIT && !$past(scl_low) && !scl_low) |-> $stable(sda_low)); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_IDLE) |-> (!scl_low && !sda_low)); // R1
  AST_DONE_AFTER_STOP_EDGE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!running && !sda_low && !scl_low)); // R3

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             go,
  input  logic             seq_done,
  input  logic             seq_nack,
  input  logic             rd_we,
  input  logic             rd_idx,
  input  logic [7:0]       rd_data,
  output logic [7:0]       dev,
  output logic [7:0]       tx0,
  output logic [7:0]       tx1,
  output logic [DIV_W-1:0] div,
  output logic             len
);

  logic [7:0] rd0_q, rd1_q;
  logic       busy_q, ake_q;
  logic       wr_ok;

  assign wr_ok = we && !busy_q;
  assign go    = wr_ok && addr == A_CSR && wdata[CSR_GO];

  always_ff @(posedge clk) begin
    if (rst) begin
      dev    <= 8'd0;
      tx0    <= 8'd0;
      tx1    <= 8'd0;
      div    <= DIV_W'(DIV_INIT);
      len    <= 1'b0;
      rd0_q  <= 8'd0;
      rd1_q  <= 8'd0;
      busy_q <= 1'b0;
      ake_q  <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (addr)
          A_DEV:   dev <= wdata;
          A_TX0:   tx0 <= wdata;
          A_TX1:   tx1 <= wdata;
          A_DIV:   div <= DIV_W'(wdata);
          A_CSR:   len <= wdata[CSR_LEN];
          default: ;
        endcase
      end
      if (go)            busy_q <= 1'b1;
      else if (seq_done) busy_q <= 1'b0;
      if (go)            ake_q <= 1'b0;
      else if (seq_nack) ake_q <= 1'b1;
      if (rd_we) begin
        if (rd_idx) rd1_q <= rd_data;
        else        rd0_q <= rd_data;
      end
    end
  end

  always_comb begin
    case (addr)
      A_DEV:   rdata = dev;
      A_TX0:   rdata = tx0;
      A_TX1:   rdata = tx1;
      A_DIV:   rdata = 8'(div);
      A_RD0:   rdata = rd0_q;
      A_RD1:   rdata = rd1_q;
      A_CSR:   rdata = csr_pack(len, busy_q, ake_q);
      default: rdata = 8'd0;
    endcase
  end

  AST_BUSY_DROPS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !busy_q); // R3
  AST_ACKERR_CLEARED_AT_GO: assert property (@(posedge clk) disable iff (rst)
    go |=> !ake_q); // R8
  AST_ACKERR_SET_ON_NACK: assert property (@(posedge clk) disable iff (rst)
    seq_nack |=> ake_q); // R7
  AST_DEV_LOCKED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_q && we && addr == A_DEV) |=> $stable(dev)); // R9
  AST_RD1_KEPT_ON_FIRST: assert property (@(posedge clk) disable iff (rst)
    (rd_we && !rd_idx) |=> $stable(rd1_q)); // R6

endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master #(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull
);

  logic             go, seq_done, seq_nack, rd_we, rd_idx, len, running, tick;
  logic [7:0]       rd_data, dev, tx0, tx1;
  logic [DIV_W-1:0] div;

  i2cm_regs #(.DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .go(go), .seq_done(seq_done), .seq_nack(seq_nack),
    .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
    .dev(dev), .tx0(tx0), .tx1(tx1), .div(div), .len(len)
  );

  i2cm_qtr_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(running), .div(div), .tick(tick)
  );

  i2cm_seq u_seq (
    .clk(clk), .rst(rst), .tick(tick), .go(go), .len(len), .dev_addr(dev),
    .tx0(tx0), .tx1(tx1), .sda_in(sda_in), .running(running), .done(seq_done),
    .nack_evt(seq_nack), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
    .scl_low(scl_pull), .sda_low(sda_pull)
  );

endmodule

// File: tb/i2c_reg_master_test.sv
module i2c_reg_master_test;

  localparam logic [2:0] O_DEV = 3'd0, O_TX0 = 3'd1, O_TX1 = 3'd2, O_DIV = 3'd3,
                         O_RD0 = 3'd4, O_RD1 = 3'd5, O_CSR = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  wire  [7:0] rdata;
  wire        scl_pull, sda_pull;
  logic       slv_pull = 1'b0;
  wire        scl_line = !scl_pull;
  wire        sda_line = !sda_pull && !slv_pull;

  i2c_reg_master uut (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural slave and bus monitor, evaluated every clock
  logic [7:0] rx_q[$];
  logic       mack_q[$];
  logic [7:0] tx_q[$];
  int   nack_at = -1, bitpos = -1, bytepos = 0, stops = 0, viol = 0, hi_cnt = 0, last_hi = 0;
  logic in_txn = 1'b0, rw = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1;
  logic [7:0] cur = 8'd0, txb = 8'hFF;

  always @(negedge clk) begin : slave
    logic c, s, tx_mode;
    c = scl_line;
    s = sda_line;
    if (!rst) begin
      if (c != prev_scl && s != prev_sda) viol++;
      if (c) hi_cnt++;
      if (prev_scl && c && prev_sda && !s) begin
        in_txn = 1'b1; bitpos = -1; bytepos = 0; rw = 1'b0; slv_pull = 1'b0;
      end else if (prev_scl && c && !prev_sda && s) begin
        if (in_txn) stops++;
        in_txn = 1'b0; slv_pull = 1'b0;
      end else if (in_txn) begin
        tx_mode = rw && bytepos > 0;
        if (!prev_scl && c) begin
          if (bitpos >= 0 && bitpos < 8 && !tx_mode) cur = {cur[6:0], s};
          if (bitpos == 8 && tx_mode) mack_q.push_back(s);
        end
        if (prev_scl && !c) begin
          last_hi = hi_cnt;
          bitpos++;
          if (bitpos == 8) begin
            if (tx_mode) slv_pull = 1'b0;
            else begin
              rx_q.push_back(cur);
              if (bytepos == 0) rw = cur[0];
              slv_pull = (nack_at != bytepos);
            end
          end else if (bitpos == 9) begin
            slv_pull = 1'b0; bytepos++; bitpos = 0;
            if (rw) begin
              txb = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hFF;
              slv_pull = !txb[7];
            end
          end else if (bitpos > 0 && tx_mode) begin
            slv_pull = !txb[7 - bitpos];
          end
        end
      end
      if (!c) hi_cnt = 0;
    end
    prev_scl = c;
    prev_sda = s;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle(output logic [7:0] csr);
    for (int i = 0; i < 20000; i++) begin
      rd(O_CSR, csr);
      if (!csr[1]) break;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_rx(input string tag, input int n, input int b0, input int b1, input int b2);
    chk({tag, " count"}, rx_q.size(), n);
    if (rx_q.size() > 0 && n > 0) chk({tag, " byte0"}, rx_q[0], b0);
    if (rx_q.size() > 1 && n > 1) chk({tag, " byte1"}, rx_q[1], b1);
    if (rx_q.size() > 2 && n > 2) chk({tag, " byte2"}, rx_q[2], b2);
  endtask

  task automatic clear_q();
    rx_q.delete(); mack_q.delete(); tx_q.delete();
  endtask

  initial begin
    logic [7:0] v;
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R2: reset values
    rd(O_DEV, v); chk("R1 dev reset", v, 8'h00);
    rd(O_TX1, v); chk("R1 tx1 reset", v, 8'h00);
    rd(O_RD1, v); chk("R1 rd1 reset", v, 8'h00);
    rd(O_CSR, v); chk("R2 csr reset", v, 8'h00);
    rd(O_DIV, v); chk("R1 div reset", v, 8'h03);
    chk("R1 bus released", {scl_pull, sda_pull}, 0);

    // R11: result registers not writable
    wr(O_RD0, 8'h55); wr(O_RD1, 8'hAA);
    rd(O_RD0, v); chk("R11 rd0 write ignored", v, 8'h00);
    rd(O_RD1, v); chk("R11 rd1 write ignored", v, 8'h00);

    // R4 / R3 / R9: two-byte write with writes during busy
    clear_q(); s0 = stops;
    wr(O_DEV, 8'hA4); wr(O_TX0, 8'h5A); wr(O_TX1, 8'hC3);
    wr(O_CSR, 8'h03);
    rd(O_CSR, v); chk("R3 busy after start", v, 8'h03);
    wr(O_DEV, 8'h11); wr(O_TX1, 8'hEE); wr(O_DIV, 8'h07); wr(O_CSR, 8'h00);
    wait_idle(v);
    chk("R3 busy cleared, R9 len kept", v, 8'h01);
    chk_rx("R4 write bytes", 3, 8'hA4, 8'h5A, 8'hC3);
    chk("R3 stop seen", stops - s0, 1);
    rd(O_DEV, v); chk("R9 dev unchanged", v, 8'hA4);
    rd(O_DIV, v); chk("R9 div unchanged", v, 8'h03);
    chk("R10 scl high width div3", last_hi, 8);

    // R6: one-byte write
    clear_q();
    wr(O_DEV, 8'h30); wr(O_TX0, 8'h77); wr(O_CSR, 8'h02);
    wait_idle(v);
    chk_rx("R6 one-byte write", 2, 8'h30, 8'h77, 0);
    chk("R6 csr", v, 8'h00);

    // R5: two-byte read
    clear_q();
    tx_q.push_back(8'hE1); tx_q.push_back(8'h3C);
    wr(O_DEV, 8'h91); wr(O_CSR, 8'h03);
    wait_idle(v);
    chk_rx("R5 read address", 1, 8'h91, 0, 0);
    rd(O_RD0, v); chk("R5 first read byte", v, 8'hE1);
    rd(O_RD1, v); chk("R5 second read byte", v, 8'h3C);
    chk("R5 master ack count", mack_q.size(), 2);
    if (mack_q.size() == 2) begin
      chk("R5 ack after first", mack_q[0], 0);
      chk("R5 nack after last", mack_q[1], 1);
    end

    // R6: one-byte read leaves second register
    clear_q();
    tx_q.push_back(8'h42);
    wr(O_CSR, 8'h02);
    wait_idle(v);
    rd(O_RD0, v); chk("R6 one-byte read rd0", v, 8'h42);
    rd(O_RD1, v); chk("R6 rd1 unchanged", v, 8'h3C);
    chk("R6 single nack", mack_q.size() == 1 && mack_q[0] == 1'b1, 1);

    // R7: nack on address
    clear_q(); s0 = stops; nack_at = 0;
    wr(O_DEV, 8'h50); wr(O_CSR, 8'h03);
    wait_idle(v);
    chk("R7 addr nack csr", v, 8'h05);
    chk_rx("R7 addr nack bytes", 1, 8'h50, 0, 0);
    chk("R7 stop after nack", stops - s0, 1);

    // R7: nack on first write data byte
    clear_q(); nack_at = 1;
    wr(O_DEV, 8'hA4); wr(O_TX0, 8'h12); wr(O_TX1, 8'h34); wr(O_CSR, 8'h03);
    wait_idle(v);
    chk("R7 data nack csr", v, 8'h05);
    chk_rx("R7 data nack abandon", 2, 8'hA4, 8'h12, 0);

    // R8: sticky error, cleared at next start
    wr(O_CSR, 8'h00);
    rd(O_CSR, v); chk("R8 error sticky", v, 8'h04);
    clear_q(); nack_at = -1;
    wr(O_DEV, 8'h30); wr(O_TX0, 8'h99); wr(O_CSR, 8'h02);
    rd(O_CSR, v); chk("R8 error cleared at start", v, 8'h02);
    wait_idle(v);
    chk("R8 clean finish", v, 8'h00);
    chk_rx("R8 bytes", 2, 8'h30, 8'h99, 0);

    // R10: divider change
    clear_q();
    wr(O_DIV, 8'h01); wr(O_CSR, 8'h02);
    wait_idle(v);
    chk("R10 scl high width div1", last_hi, 4);
    chk_rx("R10 bytes at div1", 2, 8'h30, 8'h99, 0);
    chk("R10 sda never moved with scl", viol, 0);

    summary();
    $finish;
  end

endmodule